// File: doc/BRIEF.md
# Four-Pair Complementary PWM Generator

This block produces four pulse-width modulated waveforms, each as a pair of a true output and its inverse. One down-counter, fed through a selectable clock prescaler, sets the period for all four generators. Each generator drives its true output high while the count lies between its falling-edge value (exclusive) and its rising-edge value (inclusive). An optional dead band holds both outputs of a pair low for a set number of counter ticks after every switch. This gives bridge drivers time to turn off one side before the other turns on.

Software programs the block through a plain write port. Edge values can be rewritten while the timer runs. New values go into holding registers and are applied together at the next reload, so no period is lost or cut short. A broadcast mode drives all four pairs from generator 0's waveform. Each pair still has its own enable and can still be combined with the next pair by AND or OR gating.

Top module: `cpwm_array`

## Requirements
- R1: After reset all eight outputs are low and stay low until the timer is started; the counter does not run while the run bit is clear.
- R2: The counter counts down from the reload value to zero and then reloads, so one period lasts reload+1 counter ticks; the prescaler select (control bits 8:7) gives one tick every 1, 2, 4 or 8 clocks for codes 00, 01, 10 and 11.
- R3: With no dead band and no gating, a pair's true output is high exactly while the count is above its falling value and not above its rising value, and the inverse output is high otherwise; a rising value not above the falling value keeps the true output low.
- R4: The dead-band field (control bits 12:9) holds both outputs of a pair low for that many ticks after each change of the generator's level; 0 gives no dead band.
- R5: With the broadcast bit (control bit 2) set, every enabled pair carries generator 0's waveform on the same clock.
- R6: A pair drives anything only when the run bit (bit 0), the multi-output enable (bit 1) and that pair's enable (bit 3+pair) are all set; otherwise both of its outputs are low, in broadcast mode as well.
- R7: Each pair has a 2-bit gating code at bits 2p+1:2p of the gating register (address 2): 00 no gating, 01 AND with pair (p+1) mod 4, 10 OR with pair (p+1) mod 4, 11 treated as 00; the true outputs are combined with each other and the inverse outputs with each other.
- R8: Edge values written while running are applied only at a reload, so the waveform never skips a period and each period uses one consistent pair of edges.
- R9: Register addresses: 0 control, 1 reload, 2 gating, 4+2g rising value and 5+2g falling value of generator g.
- R10: Without gating, the two outputs of a pair are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| out_p | output | 4 | True output of each pair |
| out_n | output | 4 | Inverse output of each pair |

## Verification
The four generators are set to contrasting duty cycles: a mid-period pulse, a pulse that ends at zero, one that covers all but one count, and one whose rising value is below its falling value. Counting high cycles over whole periods then separates compare errors from counter-length errors. The same set is repeated at divide-by-4, with a one-tick dead band, and with mixed AND, OR and reserved gating codes; each run shifts the expected counts in its own way, so a fault in the prescaler, the dead band or the gating shows up as a different count. Broadcast runs compare every enabled pair against pair 0, with one pair switched off. Finally, a rising value is rewritten mid-run, and the bench checks the gap between rising edges for a skipped period and then checks the new duty cycle.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

   typedef enum logic [1:0] {
      GATE_NONE = 2'b00,
      GATE_AND  = 2'b01,
      GATE_OR   = 2'b10,
      GATE_RSVD = 2'b11
   } gate_e;

   // control word field positions shared by top and checker
   localparam int unsigned CTL_RUN    = 0;
   localparam int unsigned CTL_MULTI  = 1;
   localparam int unsigned CTL_MASTER = 2;
   localparam int unsigned CTL_EN_LSB = 3;

   // register addresses
   localparam int unsigned ADR_CTRL   = 0;
   localparam int unsigned ADR_RELOAD = 1;
   localparam int unsigned ADR_GATE   = 2;
   localparam int unsigned ADR_EDGE0  = 4;

   function automatic logic gate_fn(input gate_e mode, input logic own, input logic nbr);
      case (mode)
         GATE_AND: gate_fn = own & nbr;
         GATE_OR:  gate_fn = own | nbr;
         default:  gate_fn = own;
      endcase
   endfunction

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] div_sel,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt,
   output logic             tick,
   output logic             load
);
   localparam int unsigned PRE_W = (1 << SEL_W) - 1;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] pre_lim;

   // power-of-two divide: the shift wraps to zero at the top code, minus one gives all ones
   assign pre_lim = ({{(PRE_W-1){1'b0}}, 1'b1} << div_sel) - 1'b1;
   assign tick    = run && (pre_q == pre_lim);
   assign load    = !run || (tick && (cnt == '0));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt   <= '0;
      end else if (!run) begin
         pre_q <= '0;
         cnt   <= reload;
      end else begin
         pre_q <= tick ? '0 : pre_q + 1'b1;
         if (tick) begin
            cnt <= (cnt == '0) ? reload : cnt - 1'b1;
         end
      end
   end

endmodule

// File: rtl/cpwm_slice.sv
module cpwm_slice #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             load,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] rise_sh,
   input  logic [CNT_W-1:0] fall_sh,
   input  logic [DLY_W-1:0] dly,
   output logic             t_out,
   output logic             c_out
);
   logic [CNT_W-1:0] rise_a;
   logic [CNT_W-1:0] fall_a;
   logic             lvl_q;
   logic             lvl_d;
   logic [DLY_W-1:0] dead_q;

   assign lvl_d = active && (cnt <= rise_a) && (cnt > fall_a);

   // active edges change only at reload so each period is self-consistent
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rise_a <= '0;
         fall_a <= '0;
      end else if (load) begin
         rise_a <= rise_sh;
         fall_a <= fall_sh;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         lvl_q  <= 1'b0;
         dead_q <= '0;
      end else begin
         lvl_q <= lvl_d;
         if (lvl_d != lvl_q) begin
            dead_q <= dly;
         end else if (tick && (dead_q != '0)) begin
            dead_q <= dead_q - 1'b1;
         end
      end
   end

   assign t_out = active && lvl_q && (dead_q == '0);
   assign c_out = active && !lvl_q && (dead_q == '0);

endmodule

// File: rtl/cpwm_route.sv
module cpwm_route #(
   parameter int unsigned NUM_GEN = 4
) (
   input  logic [NUM_GEN-1:0]   t_in,
   input  logic [NUM_GEN-1:0]   c_in,
   input  logic                 master,
   input  logic                 live,
   input  logic [NUM_GEN-1:0]   en,
   input  logic [2*NUM_GEN-1:0] gate,
   output logic [NUM_GEN-1:0]   out_p,
   output logic [NUM_GEN-1:0]   out_n
);
   import cpwm_pkg::*;

   logic [NUM_GEN-1:0] src_t;
   logic [NUM_GEN-1:0] src_c;

   // broadcast select comes before gating so gating still acts per pair
   assign src_t = master ? {NUM_GEN{t_in[0]}} : t_in;
   assign src_c = master ? {NUM_GEN{c_in[0]}} : c_in;

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_pair
      localparam int unsigned NB = (g + 1) % NUM_GEN;
      gate_e mode;
      logic  pt, pc;
      assign mode = gate_e'(gate[2*g +: 2]);
      assign pt   = gate_fn(mode, src_t[g], src_t[NB]);
      assign pc   = gate_fn(mode, src_c[g], src_c[NB]);
      assign out_p[g] = live && en[g] && pt;
      assign out_n[g] = live && en[g] && pc;
   end

endmodule

// File: rtl/cpwm_array.sv
module cpwm_array #(
   parameter int unsigned NUM_GEN = 4,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned DLY_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [CNT_W-1:0]   wr_data,
   output logic [NUM_GEN-1:0] out_p,
   output logic [NUM_GEN-1:0] out_n
);
   import cpwm_pkg::*;

   localparam int unsigned SEL_LSB = CTL_EN_LSB + NUM_GEN;
   localparam int unsigned DLY_LSB = SEL_LSB + SEL_W;
   localparam int unsigned CTRL_W  = DLY_LSB + DLY_W;
   localparam int unsigned GATE_W  = 2 * NUM_GEN;

   if (NUM_GEN < 2) begin : g_bad_num
      $error("cpwm_array: NUM_GEN must be at least 2");
   end
   if (CTRL_W > CNT_W || GATE_W > CNT_W) begin : g_bad_ctrl
      $error("cpwm_array: control or gating word wider than data bus");
   end
   if (ADR_EDGE0 + 2 * NUM_GEN > (1 << ADDR_W)) begin : g_bad_addr
      $error("cpwm_array: address space too small for edge registers");
   end

   logic [CTRL_W-1:0]  ctrl_q;
   logic [CNT_W-1:0]   reload_q;
   logic [GATE_W-1:0]  gate_q;
   logic [CNT_W-1:0]   rise_sh [NUM_GEN];
   logic [CNT_W-1:0]   fall_sh [NUM_GEN];

   logic               ctl_run, ctl_multi, ctl_master, live;
   logic [NUM_GEN-1:0] ctl_en;
   logic [SEL_W-1:0]   ctl_sel;
   logic [DLY_W-1:0]   ctl_dly;

   assign ctl_run    = ctrl_q[CTL_RUN];
   assign ctl_multi  = ctrl_q[CTL_MULTI];
   assign ctl_master = ctrl_q[CTL_MASTER];
   assign ctl_en     = ctrl_q[CTL_EN_LSB +: NUM_GEN];
   assign ctl_sel    = ctrl_q[SEL_LSB +: SEL_W];
   assign ctl_dly    = ctrl_q[DLY_LSB +: DLY_W];
   assign live       = ctl_run && ctl_multi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
         gate_q   <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(ADR_CTRL))   ctrl_q   <= wr_data[CTRL_W-1:0];
         if (wr_addr == ADDR_W'(ADR_RELOAD)) reload_q <= wr_data;
         if (wr_addr == ADDR_W'(ADR_GATE))   gate_q   <= wr_data[GATE_W-1:0];
      end
   end

   logic [CNT_W-1:0] cnt;
   logic             tick, load;

   cpwm_timebase #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctl_run),
      .div_sel (ctl_sel),
      .reload  (reload_q),
      .cnt     (cnt),
      .tick    (tick),
      .load    (load)
   );

   logic [NUM_GEN-1:0] t_raw, c_raw;

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
      localparam int unsigned RA = ADR_EDGE0 + 2 * g;
      localparam int unsigned FA = RA + 1;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rise_sh[g] <= '0;
            fall_sh[g] <= '0;
         end else if (wr_en) begin
            if (wr_addr == ADDR_W'(RA)) rise_sh[g] <= wr_data;
            if (wr_addr == ADDR_W'(FA)) fall_sh[g] <= wr_data;
         end
      end

      cpwm_slice #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .active  (live),
         .load    (load),
         .tick    (tick),
         .cnt     (cnt),
         .rise_sh (rise_sh[g]),
         .fall_sh (fall_sh[g]),
         .dly     (ctl_dly),
         .t_out   (t_raw[g]),
         .c_out   (c_raw[g])
      );
   end

   cpwm_route #(.NUM_GEN(NUM_GEN)) u_route (
      .t_in   (t_raw),
      .c_in   (c_raw),
      .master (ctl_master),
      .live   (live),
      .en     (ctl_en),
      .gate   (gate_q),
      .out_p  (out_p),
      .out_n  (out_n)
   );

endmodule

// File: rtl/cpwm_array_chk.sv
module cpwm_array_chk #(
   parameter int unsigned NUM_GEN = 4,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned DLY_W   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               run,
   input logic               multi,
   input logic               master,
   input logic [NUM_GEN-1:0] en,
   input logic [2*NUM_GEN-1:0] gate,
   input logic [DLY_W-1:0]   dly,
   input logic               tick,
   input logic [CNT_W-1:0]   cnt,
   input logic [NUM_GEN-1:0] out_p,
   input logic [NUM_GEN-1:0] out_n
);
   logic no_gating;
   assign no_gating = (gate == '0);

   // R2
   cnt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && (cnt != $past(cnt))) |-> $past(tick));

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
      logic ungated;
      assign ungated = (gate[2*g +: 2] == 2'b00) || (gate[2*g +: 2] == 2'b11);

      // R6
      idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(run && multi && en[g]) |-> (!out_p[g] && !out_n[g]));

      // R10
      no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ungated |-> !(out_p[g] && out_n[g]));

      // R4
      dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(out_p[g]) && ungated && (dly != '0) && ($past(dly) != '0)) |-> $past(out_n[g] == 1'b0));

      // R5
      master_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (master && no_gating && en[g] && en[0]) |-> ((out_p[g] == out_p[0]) && (out_n[g] == out_n[0])));
   end

endmodule

bind cpwm_array cpwm_array_chk #(.NUM_GEN(NUM_GEN), .CNT_W(CNT_W), .DLY_W(DLY_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .run    (ctl_run),
   .multi  (ctl_multi),
   .master (ctl_master),
   .en     (ctl_en),
   .gate   (gate_q),
   .dly    (ctl_dly),
   .tick   (tick),
   .cnt    (cnt),
   .out_p  (out_p),
   .out_n  (out_n)
);

// File: tb/sim_cpwm_array.sv
`timescale 1ns/1ps
module sim_cpwm_array;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [3:0]  out_p, out_n;

   always #2 clk = ~clk;

   cpwm_array u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .out_p(out_p), .out_n(out_n)
   );

   typedef struct {
      int    code;
      int    exp;
      string tag;
   } item_t;

   // measurement codes: 0..3 true-high count, 4..7 inverse-high count,
   // 8 pair-0 both-low count, 9 broadcast mismatches, 10 max rising gap, 11 rising edges
   item_t sb_q[$];
   int    meas [12];
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;
   logic [3:0] en_mask = '0;

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic want(input int code, input int exp, input string tag);
      item_t it;
      it.code = code; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // R9: control 0, reload 1, gating 2, edges at 4+2g / 5+2g
   function automatic int mk(input int run, input int multi, input int mst,
                             input int en, input int sel, input int dly);
      return run | (multi << 1) | (mst << 2) | (en << 3) | (sel << 7) | (dly << 9);
   endfunction

   task automatic cfg(input int gate, input int sel, input int dly,
                      input int mst, input int en, input int multi);
      wr(0, mk(0, 0, 0, 0, 0, 0));
      wr(1, 12);
      wr(4, 8);  wr(5, 4);
      wr(6, 6);  wr(7, 0);
      wr(8, 12); wr(9, 0);
      wr(10, 3); wr(11, 7);
      wr(2, gate);
      en_mask = 4'(en);
      wr(0, mk(1, multi, mst, en, sel, dly));
   endtask

   // monitor: sample away from the edge, then pop expected items and compare
   task automatic measure(input int ncyc);
      int last;
      logic prev;
      foreach (meas[i]) meas[i] = 0;
      last = -1; prev = out_p[0];
      for (int c = 0; c < ncyc; c++) begin
         @(negedge clk);
         for (int g = 0; g < 4; g++) begin
            meas[g]   += int'(out_p[g]);
            meas[4+g] += int'(out_n[g]);
         end
         if (!out_p[0] && !out_n[0]) meas[8]++;
         for (int g = 1; g < 4; g++)
            if (en_mask[g] && (out_p[g] != out_p[0] || out_n[g] != out_n[0])) meas[9]++;
         if (out_p[0] && !prev) begin
            meas[11]++;
            if (last >= 0 && (c - last) > meas[10]) meas[10] = c - last;
            last = c;
         end
         prev = out_p[0];
      end
      while (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         check($sformatf("%s code%0d", it.tag, it.code), meas[it.code], it.exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: outputs low after reset, timer stopped
      want(0, 0, "R1"); want(4, 0, "R1"); want(3, 0, "R1"); want(7, 0, "R1");
      measure(30);

      // R3 R9 R10: base duty pattern, period 13 ticks, divide 1
      cfg(0, 0, 0, 0, 15, 1);
      settle(40);
      want(0, 16, "R3_R9"); want(4, 36, "R3");
      want(1, 24, "R3");    want(5, 28, "R3");
      want(2, 48, "R3");    want(6, 4, "R3");
      want(3, 0, "R3");     want(7, 52, "R3");
      want(11, 4, "R2");    want(10, 13, "R2");
      measure(52);

      // R2: divide-by-4 code 10
      cfg(0, 2, 0, 0, 15, 1);
      settle(160);
      want(0, 64, "R2"); want(4, 144, "R2");
      want(1, 96, "R2"); want(6, 16, "R2");
      want(11, 4, "R2"); want(10, 52, "R2");
      measure(208);

      // R4: one-tick dead band
      cfg(0, 0, 1, 0, 15, 1);
      settle(40);
      want(0, 12, "R4"); want(4, 32, "R4"); want(8, 8, "R4");
      want(1, 20, "R4"); want(5, 24, "R4");
      want(2, 44, "R4"); want(6, 0, "R4");
      want(3, 0, "R4");  want(7, 52, "R4");
      measure(52);

      // R7: pair0 OR, pair1 AND, pair2 none, pair3 reserved
      cfg(8'hC6, 0, 0, 0, 15, 1);
      settle(40);
      want(0, 32, "R7"); want(4, 44, "R7");
      want(1, 24, "R7"); want(5, 4, "R7");
      want(2, 48, "R7"); want(6, 4, "R7");
      want(3, 0, "R7");  want(7, 52, "R7");
      measure(52);

      // R5: broadcast to all pairs
      cfg(0, 0, 0, 1, 15, 1);
      settle(40);
      want(9, 0, "R5"); want(3, 16, "R5"); want(7, 36, "R5"); want(2, 16, "R5");
      measure(52);

      // R6: broadcast with pair 2 disabled
      cfg(0, 0, 0, 1, 11, 1);
      settle(40);
      want(2, 0, "R6"); want(6, 0, "R6"); want(9, 0, "R6"); want(1, 16, "R6");
      measure(52);

      // R6: multi-output enable clear keeps everything low
      cfg(0, 0, 0, 0, 15, 0);
      settle(40);
      want(0, 0, "R6"); want(4, 0, "R6"); want(2, 0, "R6"); want(7, 0, "R6");
      measure(52);

      // R8: rewrite rising edge mid-run, no period skipped, new duty later
      cfg(0, 0, 0, 0, 15, 1);
      settle(45);
      wr(4, 10);
      want(10, 13, "R8");
      measure(65);
      settle(30);
      want(0, 24, "R8"); want(4, 28, "R8"); want(11, 4, "R8");
      measure(52);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule